// File: doc/BRIEF.md
# Accelerator Core Translation Unit with Remote Fault Reporting

This block translates virtual addresses for a single throughput accelerator core that shares a virtual address space with the host processors. It keeps a small fully associative cache of recent page translations and a page-table base register. The base register is loaded when a task starts on the core. A lookup that misses starts a two-level hardware table walk over a single-outstanding memory read port. A completed walk fills one cache slot and answers the lookup.

The core never services a page fault itself. When the walk reads an entry whose present bit is clear, the unit stops and raises a fault request to a central controller. The request carries a cause code, the page-table base in use and the faulting address. Once the controller acknowledges that the fault is resolved, the walk starts over from the base. The host processors can order a shootdown through a flush input. A flush clears every cached translation at once. The core itself has no way to change a translation.

Top module: `accel_tlb`

## Requirements
- R1: After reset `req_ready` is high, `resp_valid`, `mem_req_valid` and `fault_valid` are low, and every slot is empty, so the first lookup of any page misses.
- R2: A lookup accepted (`req_valid` and `req_ready`) for a cached page raises `resp_valid` in the next cycle with `resp_paddr` = {cached frame, vaddr[11:0]} and issues no memory read.
- R3: On a miss the unit reads the directory entry at {base[31:12], vaddr[31:22], 2'b00} and then the leaf entry at {dir[31:12], vaddr[21:12], 2'b00}, and returns `resp_paddr` = {leaf[31:12], vaddr[11:0]}. `resp_valid` stays low and `req_ready` stays low until the walk is done.
- R4: A completed walk writes its translation into one of 8 slots, chosen round-robin. A later lookup of that page hits until the slot is reused or flushed.
- R5: An entry with bit 0 clear raises `fault_valid` with `fault_cause` 1 (directory level) or 2 (leaf level), `fault_root` equal to the base register and `fault_vaddr` equal to the lookup address. These hold until `fault_ack`, and no response is given meanwhile.
- R6: `fault_ack` during a fault restarts the walk in the next cycle with a directory read taken from the base register.
- R7: A `flush` pulse empties every slot, so every page misses on its next lookup.
- R8: A flush that arrives while a walk is in progress discards that walk. No slot is filled from it, the walk restarts from the base, and the response carries the result of the restarted walk.
- R9: A flush in the same cycle as an accepted lookup makes that lookup a miss, even if its page was cached.
- R10: A `task_start` pulse loads `task_root` into the base register, and later walks use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| task_start | input | 1 | Load the page-table base register |
| task_root | input | 32 | Base value taken from the task descriptor |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Unit idle, lookup can be accepted |
| resp_valid | output | 1 | Translation result valid (one cycle) |
| resp_paddr | output | 32 | Physical address result |
| mem_req_valid | output | 1 | Walker read request (one-cycle pulse) |
| mem_req_addr | output | 32 | Walker read address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 32 | Table entry, bit 0 = present |
| fault_valid | output | 1 | Fault request to the central controller |
| fault_cause | output | 4 | 1 = directory absent, 2 = leaf absent |
| fault_root | output | 32 | Base register value at the fault |
| fault_vaddr | output | 32 | Faulting virtual address |
| fault_ack | input | 1 | Fault resolved, retry the walk |
| flush | input | 1 | Host shootdown, invalidate all slots |

## Verification
The shootdown can land on the same cycle as another function. One case is a lookup acceptance: the bench raises `flush` together with `req_valid` for a page it knows is cached, and the result must arrive with miss timing. The other case is a walk in flight: the bench pulses `flush` at a fixed walk cycle in directed cases, and at random walk cycles during the random phase, sometimes on the very cycle the memory returns data. In that case the bench expects at least one extra directory read and a correct address. Hit or miss is judged from the response cycle against a bench-side model of the slots, and that model is cleared at each flush the bench issues.

// File: rtl/atlb_pkg.sv
package atlb_pkg;

    localparam int CAUSE_W = 4;
    localparam logic [CAUSE_W-1:0] CAUSE_DIR_ABSENT  = 4'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_LEAF_ABSENT = 4'd2;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'd0,
        WK_DIR   = 2'd1,
        WK_LEAF  = 2'd2,
        WK_FAULT = 2'd3
    } wk_state_e;

endpackage

// File: rtl/atlb_entries.sv
module atlb_entries #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   look_vpn,
    input  logic               flush,
    input  logic               fill_en,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PPN_W-1:0]   fill_ppn,
    output logic               hit,
    output logic [PPN_W-1:0]   hit_ppn,
    output logic [ENTRIES-1:0] valid_vec
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic [ENTRIES-1:0]            valid;
        logic [ENTRIES-1:0][VPN_W-1:0] tag;
        logic [ENTRIES-1:0][PPN_W-1:0] ppn;
        logic [PTR_W-1:0]              ptr;
    } ent_t;

    ent_t st_d, st_q;
    logic [ENTRIES-1:0] match;

    // one comparator per slot
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign match[g] = st_q.valid[g] && (st_q.tag[g] == look_vpn);
    end

    always_comb begin
        hit     = |match;
        hit_ppn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) hit_ppn = hit_ppn | st_q.ppn[i];
        end

        st_d = st_q;
        if (flush) begin
            st_d.valid = '0;
        end else if (fill_en) begin
            st_d.valid[st_q.ptr] = 1'b1;
            st_d.tag[st_q.ptr]   = fill_vpn;
            st_d.ppn[st_q.ptr]   = fill_ppn;
            st_d.ptr = (st_q.ptr == PTR_W'(ENTRIES - 1)) ? '0 : st_q.ptr + PTR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_vec = st_q.valid;

endmodule

// File: rtl/atlb_walk.sv
module atlb_walk
    import atlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    task_start,
    input  logic [PA_W-1:0]         task_root,
    input  logic                    req_valid,
    input  logic [VA_W-1:0]         req_vaddr,
    output logic                    req_ready,
    output logic                    resp_valid,
    output logic [PA_W-1:0]         resp_paddr,
    output logic                    mem_req_valid,
    output logic [PA_W-1:0]         mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [PA_W-1:0]         mem_rsp_data,
    output logic                    fault_valid,
    output logic [CAUSE_W-1:0]      fault_cause,
    output logic [PA_W-1:0]         fault_root,
    output logic [VA_W-1:0]         fault_vaddr,
    input  logic                    fault_ack,
    input  logic                    flush,
    output logic [VA_W-PAGE_BITS-1:0] look_vpn,
    input  logic                    hit,
    input  logic [PA_W-PAGE_BITS-1:0] hit_ppn,
    output logic                    fill_en,
    output logic [VA_W-PAGE_BITS-1:0] fill_vpn,
    output logic [PA_W-PAGE_BITS-1:0] fill_ppn
);

    localparam int IDX_W = PAGE_BITS - 2;
    localparam int DIR_W = VA_W - PAGE_BITS - IDX_W;
    localparam int PPN_W = PA_W - PAGE_BITS;

    typedef struct packed {
        wk_state_e          state;
        logic [VA_W-1:0]    vaddr;
        logic [PA_W-1:0]    root;
        logic               resp_valid;
        logic [PA_W-1:0]    resp_paddr;
        logic               mem_req_valid;
        logic [PA_W-1:0]    mem_req_addr;
        logic [CAUSE_W-1:0] cause;
        logic               discard;
    } ctl_t;

    ctl_t c_d, c_q;

    function automatic logic [PA_W-1:0] dir_addr(input logic [PA_W-1:0] base,
                                                 input logic [VA_W-1:0] va);
        return {base[PA_W-1:PAGE_BITS], va[VA_W-1 -: DIR_W], 2'b00};
    endfunction

    function automatic logic [PA_W-1:0] leaf_addr(input logic [PA_W-1:0] pte,
                                                  input logic [VA_W-1:0] va);
        return {pte[PA_W-1:PAGE_BITS], va[PAGE_BITS+IDX_W-1:PAGE_BITS], 2'b00};
    endfunction

    logic pte_unused;
    assign pte_unused = ^mem_rsp_data[PAGE_BITS-1:1];

    logic [PPN_W-1:0] rsp_ppn;
    logic             rsp_present;
    logic             drop_walk;
    assign rsp_ppn     = mem_rsp_data[PA_W-1:PAGE_BITS];
    assign rsp_present = mem_rsp_data[0];
    assign drop_walk   = c_q.discard || flush;

    always_comb begin
        c_d               = c_q;
        c_d.resp_valid    = 1'b0;
        c_d.mem_req_valid = 1'b0;
        fill_en           = 1'b0;
        fill_vpn          = c_q.vaddr[VA_W-1:PAGE_BITS];
        fill_ppn          = rsp_ppn;

        if (task_start) c_d.root = task_root;

        unique case (c_q.state)
            WK_IDLE: begin
                if (req_valid) begin
                    c_d.vaddr = req_vaddr;
                    if (hit && !flush) begin
                        c_d.resp_valid = 1'b1;
                        c_d.resp_paddr = {hit_ppn, req_vaddr[PAGE_BITS-1:0]};
                    end else begin
                        c_d.state         = WK_DIR;
                        c_d.mem_req_valid = 1'b1;
                        c_d.mem_req_addr  = dir_addr(c_q.root, req_vaddr);
                        c_d.discard       = 1'b0;
                    end
                end
            end
            WK_DIR: begin
                if (flush) c_d.discard = 1'b1;
                if (mem_rsp_valid) begin
                    if (drop_walk) begin
                        c_d.mem_req_valid = 1'b1;
                        c_d.mem_req_addr  = dir_addr(c_q.root, c_q.vaddr);
                        c_d.discard       = 1'b0;
                    end else if (!rsp_present) begin
                        c_d.state = WK_FAULT;
                        c_d.cause = CAUSE_DIR_ABSENT;
                    end else begin
                        c_d.state         = WK_LEAF;
                        c_d.mem_req_valid = 1'b1;
                        c_d.mem_req_addr  = leaf_addr(mem_rsp_data, c_q.vaddr);
                    end
                end
            end
            WK_LEAF: begin
                if (flush) c_d.discard = 1'b1;
                if (mem_rsp_valid) begin
                    if (drop_walk) begin
                        c_d.state         = WK_DIR;
                        c_d.mem_req_valid = 1'b1;
                        c_d.mem_req_addr  = dir_addr(c_q.root, c_q.vaddr);
                        c_d.discard       = 1'b0;
                    end else if (!rsp_present) begin
                        c_d.state = WK_FAULT;
                        c_d.cause = CAUSE_LEAF_ABSENT;
                    end else begin
                        fill_en        = 1'b1;
                        c_d.state      = WK_IDLE;
                        c_d.resp_valid = 1'b1;
                        c_d.resp_paddr = {rsp_ppn, c_q.vaddr[PAGE_BITS-1:0]};
                    end
                end
            end
            WK_FAULT: begin
                if (fault_ack) begin
                    c_d.state         = WK_DIR;
                    c_d.mem_req_valid = 1'b1;
                    c_d.mem_req_addr  = dir_addr(c_q.root, c_q.vaddr);
                    c_d.discard       = 1'b0;
                end
            end
            default: c_d.state = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q       <= '0;
            c_q.state <= WK_IDLE;
        end else begin
            c_q <= c_d;
        end
    end

    assign look_vpn      = req_vaddr[VA_W-1:PAGE_BITS];
    assign req_ready     = (c_q.state == WK_IDLE);
    assign resp_valid    = c_q.resp_valid;
    assign resp_paddr    = c_q.resp_paddr;
    assign mem_req_valid = c_q.mem_req_valid;
    assign mem_req_addr  = c_q.mem_req_addr;
    assign fault_valid   = (c_q.state == WK_FAULT);
    assign fault_cause   = c_q.cause;
    assign fault_root    = c_q.root;
    assign fault_vaddr   = c_q.vaddr;

endmodule

// File: rtl/accel_tlb.sv
module accel_tlb
    import atlb_pkg::*;
#(
    parameter int VA_W      = 32,
    parameter int PA_W      = 32,
    parameter int PAGE_BITS = 12,
    parameter int ENTRIES   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               task_start,
    input  logic [PA_W-1:0]    task_root,
    input  logic               req_valid,
    input  logic [VA_W-1:0]    req_vaddr,
    output logic               req_ready,
    output logic               resp_valid,
    output logic [PA_W-1:0]    resp_paddr,
    output logic               mem_req_valid,
    output logic [PA_W-1:0]    mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic [PA_W-1:0]    mem_rsp_data,
    output logic               fault_valid,
    output logic [CAUSE_W-1:0] fault_cause,
    output logic [PA_W-1:0]    fault_root,
    output logic [VA_W-1:0]    fault_vaddr,
    input  logic               fault_ack,
    input  logic               flush
);

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;

    logic [VPN_W-1:0]   look_vpn;
    logic               hit;
    logic [PPN_W-1:0]   hit_ppn;
    logic               fill_en;
    logic [VPN_W-1:0]   fill_vpn;
    logic [PPN_W-1:0]   fill_ppn;
    logic [ENTRIES-1:0] valid_vec;

    atlb_entries #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PPN_W   (PPN_W)
    ) u_entries (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_vpn  (look_vpn),
        .flush     (flush),
        .fill_en   (fill_en),
        .fill_vpn  (fill_vpn),
        .fill_ppn  (fill_ppn),
        .hit       (hit),
        .hit_ppn   (hit_ppn),
        .valid_vec (valid_vec)
    );

    atlb_walk #(
        .VA_W      (VA_W),
        .PA_W      (PA_W),
        .PAGE_BITS (PAGE_BITS)
    ) u_walk (
        .clk           (clk),
        .rst_n         (rst_n),
        .task_start    (task_start),
        .task_root     (task_root),
        .req_valid     (req_valid),
        .req_vaddr     (req_vaddr),
        .req_ready     (req_ready),
        .resp_valid    (resp_valid),
        .resp_paddr    (resp_paddr),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .fault_valid   (fault_valid),
        .fault_cause   (fault_cause),
        .fault_root    (fault_root),
        .fault_vaddr   (fault_vaddr),
        .fault_ack     (fault_ack),
        .flush         (flush),
        .look_vpn      (look_vpn),
        .hit           (hit),
        .hit_ppn       (hit_ppn),
        .fill_en       (fill_en),
        .fill_vpn      (fill_vpn),
        .fill_ppn      (fill_ppn)
    );

endmodule

// File: rtl/atlb_checker.sv
module atlb_checker #(
    parameter int PA_W    = 32,
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               resp_valid,
    input logic               mem_req_valid,
    input logic               fault_valid,
    input logic [3:0]         fault_cause,
    input logic [PA_W-1:0]    fault_root,
    input logic               fault_ack,
    input logic               flush,
    input logic               hit,
    input logic [ENTRIES-1:0] valid_vec
);

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && hit && !flush) |=> (resp_valid && !mem_req_valid)); // R2

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R3

    AST_ONE_FILL_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(valid_vec) <= $countones($past(valid_vec)) + 1); // R4

    AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && !fault_ack) |=> (fault_valid && $stable(fault_root) && $stable(fault_cause))); // R5

    AST_FAULT_NO_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |-> (!resp_valid && !req_ready)); // R5

    AST_ACK_RETRIES: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && fault_ack) |=> (mem_req_valid && !fault_valid)); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_vec == '0)); // R7

    AST_FLUSH_LOOKUP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && flush) |=> (!resp_valid && mem_req_valid)); // R9

endmodule

bind accel_tlb atlb_checker #(
    .PA_W    (PA_W),
    .ENTRIES (ENTRIES)
) i_atlb_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .resp_valid    (resp_valid),
    .mem_req_valid (mem_req_valid),
    .fault_valid   (fault_valid),
    .fault_cause   (fault_cause),
    .fault_root    (fault_root),
    .fault_ack     (fault_ack),
    .flush         (flush),
    .hit           (hit),
    .valid_vec     (valid_vec)
);

// File: tb/test_accel_tlb.sv
`timescale 1ns/1ps
module test_accel_tlb;

    localparam int NENT = 8;
    localparam int NPOOL = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        task_start = 1'b0;
    logic [31:0] task_root = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        fault_valid;
    logic [3:0]  fault_cause;
    logic [31:0] fault_root;
    logic [31:0] fault_vaddr;
    logic        fault_ack = 1'b0;
    logic        flush = 1'b0;

    always #2.5 clk = ~clk;

    accel_tlb i_accel_tlb (
        .clk(clk), .rst_n(rst_n), .task_start(task_start), .task_root(task_root),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_root(fault_root),
        .fault_vaddr(fault_vaddr), .fault_ack(fault_ack), .flush(flush)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // page-table contents: bit 0 present, absent where addr[6:2]==31 until repaired
    bit          repaired = 0;
    logic [31:0] cur_root = '0;
    logic [31:0] cur_va = '0;
    int          reads = 0;
    int          faults = 0;
    bit          after_ack = 0;

    function automatic logic [31:0] pte_of(input logic [31:0] a, input bit fx);
        logic [31:0] h;
        logic        pres;
        h = (a * 32'h9E37_79B1) ^ (a >> 7);
        pres = !((a[6:2] == 5'd31) && !fx);
        return {h[31:12], 11'd0, pres};
    endfunction

    function automatic logic [31:0] dir_of(input logic [31:0] root, input logic [31:0] va);
        return {root[31:12], va[31:22], 2'b00};
    endfunction

    function automatic logic [31:0] exp_pa(input logic [31:0] va, input logic [31:0] root);
        logic [31:0] d, l;
        d = pte_of(dir_of(root, va), 1'b1);
        l = pte_of({d[31:12], va[21:12], 2'b00}, 1'b1);
        return {l[31:12], va[11:0]};
    endfunction

    // bench model of the slots
    logic [19:0] m_vpn [NENT];
    bit          m_val [NENT];
    int          m_ptr = 0;

    task automatic m_clear();
        for (int i = 0; i < NENT; i++) m_val[i] = 0;
    endtask

    function automatic bit m_hit(input logic [19:0] vpn);
        for (int i = 0; i < NENT; i++) if (m_val[i] && m_vpn[i] == vpn) return 1;
        return 0;
    endfunction

    task automatic m_fill(input logic [19:0] vpn);
        m_vpn[m_ptr] = vpn;
        m_val[m_ptr] = 1;
        m_ptr = (m_ptr + 1) % NENT;
    endtask

    // memory responder, 1..3 cycles latency
    bit          mp_pend = 0;
    int          mp_cnt = 0;
    logic [31:0] mp_addr = '0;
    initial forever begin
        @(negedge clk);
        mem_rsp_valid = 1'b0;
        if (mp_pend) begin
            mp_cnt--;
            if (mp_cnt == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = pte_of(mp_addr, repaired);
                mp_pend = 0;
            end
        end
        if (mem_req_valid) begin
            if (after_ack) begin
                chk(mem_req_addr == dir_of(cur_root, cur_va), "R6 retry starts at directory", mem_req_addr, dir_of(cur_root, cur_va));
                after_ack = 0;
            end
            mp_addr = mem_req_addr;
            mp_cnt  = 1 + int'($urandom % 3);
            mp_pend = 1;
            reads++;
        end
    end

    // central fault controller model
    bit fa_pend = 0;
    int fa_cnt = 0;
    initial forever begin
        @(negedge clk);
        fault_ack = 1'b0;
        if (fa_pend) begin
            fa_cnt--;
            if (fa_cnt == 0) begin
                repaired = 1;
                after_ack = 1;
                fault_ack = 1'b1;
                fa_pend = 0;
            end
        end else if (fault_valid) begin
            logic [3:0] ec;
            ec = (cur_va[26:22] == 5'd31) ? 4'd1 : 4'd2;
            chk(fault_cause == ec, "R5 fault cause", 32'(fault_cause), 32'(ec));
            chk(fault_root == cur_root, "R5 fault root", fault_root, cur_root);
            chk(fault_vaddr == cur_va, "R5 fault vaddr", fault_vaddr, cur_va);
            faults++;
            fa_pend = 1;
            fa_cnt = 2;
        end
    end

    int last_reads = 0;

    task automatic do_req(input logic [31:0] va, input bit fl_same, input int fl_at,
                          input bit rnd_fl, input string tag);
        bit pred;
        bit got_hit;
        int r0;
        int cyc;
        while (!req_ready) @(negedge clk);
        repaired = 0;
        cur_va = va;
        r0 = reads;
        if (fl_same) m_clear();
        pred = m_hit(va[31:12]);
        req_valid = 1'b1;
        req_vaddr = va;
        flush = fl_same;
        @(negedge clk);
        req_valid = 1'b0;
        flush = 1'b0;
        got_hit = resp_valid;
        chk(got_hit == pred, {tag, " hit/miss timing"}, 32'(got_hit), 32'(pred));
        if (!got_hit) begin
            chk(!req_ready, {tag, " R3 busy during walk"}, 32'(req_ready), 32'd0);
            cyc = 0;
            while (!resp_valid) begin
                if ((fl_at == cyc) || (rnd_fl && ($urandom % 10 == 0))) begin
                    flush = 1'b1;
                    m_clear();
                end
                @(negedge clk);
                flush = 1'b0;
                cyc++;
            end
            m_fill(va[31:12]);
        end else begin
            chk(reads == r0, {tag, " R2 no read on hit"}, 32'(reads - r0), 32'd0);
        end
        chk(resp_paddr == exp_pa(va, cur_root), {tag, " physical address"}, resp_paddr, exp_pa(va, cur_root));
        last_reads = reads - r0;
        @(negedge clk);
    endtask

    task automatic start_task(input logic [31:0] root);
        task_start = 1'b1;
        task_root = root;
        flush = 1'b1;
        m_clear();
        cur_root = root;
        @(negedge clk);
        task_start = 1'b0;
        flush = 1'b0;
    endtask

    logic [31:0] pool [NPOOL];

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_clear();
        for (int i = 0; i < NPOOL; i++) begin
            pool[i] = ($urandom & 32'hFBF0_0000) | (32'(i) << 12);
        end
        pool[10][26:22] = 5'd31;
        pool[11][16:12] = 5'd31;

        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        chk(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 32'd0);
        chk(mem_req_valid == 1'b0, "R1 no read after reset", 32'(mem_req_valid), 32'd0);
        chk(fault_valid == 1'b0, "R1 no fault after reset", 32'(fault_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: base register loaded from the task descriptor
        start_task(32'h4567_8000);

        do_req(32'h1234_5678, 0, -1, 0, "R1 first lookup");
        do_req(32'h1234_5ABC, 0, -1, 0, "R2 repeat page");
        do_req(32'h1234_5000, 1, -1, 0, "R9 flush with lookup");
        flush = 1'b1; m_clear(); @(negedge clk); flush = 1'b0;
        do_req(32'h1234_5004, 0, -1, 0, "R7 after flush");

        // R4: round-robin reuse
        for (int i = 0; i < 9; i++) do_req(pool[i] | 32'h10, 0, -1, 0, "R4 fill");
        do_req(pool[0], 0, -1, 0, "R4 oldest evicted");
        do_req(pool[2], 0, -1, 0, "R4 survivor");
        do_req(pool[8], 0, -1, 0, "R4 newest");

        // R5/R6 faults at both levels
        do_req(pool[10], 0, -1, 0, "R5 directory fault");
        do_req(pool[11], 0, -1, 0, "R5 leaf fault");
        chk(faults == 2, "R5 fault count", 32'(faults), 32'd2);

        // R8: flush inside a walk
        flush = 1'b1; m_clear(); @(negedge clk); flush = 1'b0;
        do_req(pool[3], 0, 1, 0, "R8 flush mid walk");
        chk(last_reads >= 3, "R8 walk restarted", 32'(last_reads), 32'd3);
        do_req(pool[3], 0, -1, 0, "R8 refilled after restart");

        for (int n = 0; n < 300; n++) begin
            do_req(pool[$urandom % NPOOL] ^ ($urandom & 32'hFFF), ($urandom % 20 == 0), -1, 1, "R3 random");
        end

        // R10: new task, new base
        start_task(32'h9ABC_D000);
        for (int n = 0; n < 150; n++) begin
            do_req(pool[$urandom % NPOOL] ^ ($urandom & 32'hFFF), ($urandom % 20 == 0), -1, 1, "R10 new base");
        end

        done = 1;
        summary();
        $finish;
    end

endmodule